// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Dithered Sigma-Delta Control

This block divides a stream of single-cycle input enables by an average ratio of N + F/M, where N is a small integer and F/M is a proper fraction. Each output period counts an integer number of enables, either N or N+1. A first-order accumulator with an arbitrary modulus M chooses between the two at every period boundary. Over time the mean ratio lands on the requested fractional value.

An optional pseudorandom bit stream can perturb the accumulator so that short repeating carry patterns are broken up. The perturbation is injected differentially: each period adds the current bit and removes the previous one. The long-run mean is therefore unchanged. New settings take effect only at a period boundary. The block is meant as the digital feedback path of a frequency synthesizer loop.

Top module: `fracn_fbdiv`

## Requirements
- R1: During and immediately after synchronous reset, div_pulse and carry_out are 0 and cur_mod equals the clamped N. The first period after reset counts exactly that many enables.
- R2: Between two div_pulse assertions, the number of enables counted equals the cur_mod value shown during that period. div_pulse is high for exactly one cycle, in the cycle after the enable that completes the period. Cycles without an enable are not counted.
- R3: With dither off and 0 < F < M, every period lasts N or N+1 enables. Over the first k periods after the post-reset one, the number of N+1 periods is floor(k*F/M). Any M consecutive such periods contain exactly F periods of N+1, for a total of M*N+F enables.
- R4: carry_out is 1 for exactly those periods whose modulus is N+1.
- R5: F = 0 gives a constant division by N, whether dither is on or off.
- R6: When F >= M, including M = 0, the fraction is ignored and the division is a constant N, with dither on or off.
- R7: N values below 4 are treated as 4.
- R8: Changes to N, F or M in the middle of a period do not change that period's length. They first apply to the modulus chosen at the next boundary.
- R9: With dither on, the N+1 pattern departs from the undithered floor(k*F/M) sequence. The count of N+1 periods still stays within 2 of k*F/M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_in | input | 1 | Input enable to be divided, one count per high cycle |
| int_n | input | 7 | Integer part N of the ratio |
| frac_num | input | 20 | Fraction numerator F |
| frac_mod | input | 20 | Fraction modulus M |
| dither_en | input | 1 | Enables pseudorandom perturbation of the accumulator |
| div_pulse | output | 1 | One-cycle pulse at the end of each divided period |
| cur_mod | output | 8 | Modulus of the period in progress |
| carry_out | output | 1 | High while the period in progress uses N+1 |

## Verification
Near-exhaustive sweeps run every fraction with a modulus up to 8, at two integer values, under three enable patterns: continuous, one in three, and random. This separates counting of enables from counting of cycles and pins down the exact carry placement against floor(k*F/M). A full-width modulus with F = M-1, and a large modulus with F = 1, test accumulator width and a sparse carry rate. Separate runs cover the zero, improper and zero-modulus fractions with dither on, which catch dither leaking into integer mode. N values below the floor are also run. A mid-period reprogramming tells sampling at the boundary apart from using the settings at once. A long dithered run tells a broken-up pattern apart from a biased mean.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
   // Variant of the pseudorandom source built into the divider
   typedef enum logic {
      DITH_NONE = 1'b0,
      DITH_PRBS = 1'b1
   } dith_impl_e;
endpackage

// File: rtl/fracn_prbs.sv
module fracn_prbs #(
   parameter int          W    = 23,
   parameter int          TAP  = 18,
   parameter logic [W-1:0] SEED = W'(1)
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic bit_o
);
   if (TAP < 1 || TAP >= W) begin : g_bad_tap
      $error("fracn_prbs: TAP must lie in 1..W-1");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("fracn_prbs: SEED must be non-zero");
   end

   logic [W-1:0] st_q;
   logic         fb;

   assign fb    = st_q[W-1] ^ st_q[TAP-1];
   assign bit_o = st_q[W-1];

   always_ff @(posedge clk) begin
      if (rst)      st_q <= SEED;
      else if (adv) st_q <= {st_q[W-2:0], fb};
   end
endmodule

// File: rtl/fracn_sdacc.sv
module fracn_sdacc #(
   parameter int FW = 20
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   input  logic [FW-1:0] frac,
   input  logic [FW-1:0] modu,
   input  logic          dith_bit,
   output logic          carry_o
);
   localparam int AW = FW + 2;

   logic signed [AW-1:0] acc_q, sum_s, f_s, m_s, d_s;
   logic                 dprev_q, dnow, frac_ok;

   assign frac_ok = (frac != '0) && (frac < modu);
   assign dnow    = frac_ok & dith_bit;
   assign f_s     = $signed({2'b00, frac});
   assign m_s     = $signed({2'b00, modu});
   assign d_s     = $signed(AW'(dnow)) - $signed(AW'(dprev_q));
   assign sum_s   = acc_q + f_s + d_s;
   assign carry_o = frac_ok && (sum_s >= m_s);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         dprev_q <= 1'b0;
      end else if (step) begin
         if (!frac_ok) begin
            acc_q   <= '0;
            dprev_q <= 1'b0;
         end else begin
            acc_q   <= carry_o ? (sum_s - m_s) : sum_s;
            dprev_q <= dnow;
         end
      end
   end
endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt #(
   parameter int MW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ce,
   input  logic [MW-1:0] rst_mod,
   input  logic [MW-1:0] next_mod,
   input  logic          next_carry,
   output logic          wrap,
   output logic [MW-1:0] cnt_q,
   output logic [MW-1:0] mod_q,
   output logic          carry_q,
   output logic          pulse_q
);
   assign wrap = ce && (cnt_q == mod_q - MW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         mod_q   <= rst_mod;
         carry_q <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= wrap;
         if (wrap) begin
            cnt_q   <= '0;
            mod_q   <= next_mod;
            carry_q <= next_carry;
         end else if (ce) begin
            cnt_q   <= cnt_q + MW'(1);
         end
      end
   end
endmodule

// File: rtl/fracn_fbdiv.sv
module fracn_fbdiv
   import fracn_pkg::*;
#(
   parameter int              NW      = 7,
   parameter int              FW      = 20,
   parameter int              NMIN    = 4,
   parameter int              PRBS_W  = 23,
   parameter int              PRBS_T  = 18,
   parameter logic [PRBS_W-1:0] SEED  = PRBS_W'(23'h5A5A5),
   parameter dith_impl_e      DITH    = DITH_PRBS
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ce_in,
   input  logic [NW-1:0] int_n,
   input  logic [FW-1:0] frac_num,
   input  logic [FW-1:0] frac_mod,
   input  logic          dither_en,
   output logic          div_pulse,
   output logic [NW:0]   cur_mod,
   output logic          carry_out
);
   localparam int MW = NW + 1;

   if (NMIN < 2 || NMIN >= (1 << NW)) begin : g_bad_nmin
      $error("fracn_fbdiv: NMIN must lie in 2..2**NW-1");
   end
   if (FW < 2) begin : g_bad_fw
      $error("fracn_fbdiv: FW must be at least 2");
   end

   logic [MW-1:0] n_ext, n_eff, next_mod, cnt_q;
   logic          wrap, carry_nx, prbs_bit, dith_bit;

   assign n_ext    = {1'b0, int_n};
   assign n_eff    = (n_ext < MW'(NMIN)) ? MW'(NMIN) : n_ext;
   assign next_mod = n_eff + MW'(carry_nx);

   if (DITH == DITH_PRBS) begin : g_prbs
      fracn_prbs #(.W(PRBS_W), .TAP(PRBS_T), .SEED(SEED)) u_prbs (
         .clk   (clk),
         .rst   (rst),
         .adv   (wrap),
         .bit_o (prbs_bit)
      );
   end else begin : g_noprbs
      assign prbs_bit = 1'b0;
   end

   assign dith_bit = dither_en & prbs_bit;

   fracn_sdacc #(.FW(FW)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .step     (wrap),
      .frac     (frac_num),
      .modu     (frac_mod),
      .dith_bit (dith_bit),
      .carry_o  (carry_nx)
   );

   fracn_cnt #(.MW(MW)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .ce         (ce_in),
      .rst_mod    (n_eff),
      .next_mod   (next_mod),
      .next_carry (carry_nx),
      .wrap       (wrap),
      .cnt_q      (cnt_q),
      .mod_q      (cur_mod),
      .carry_q    (carry_out),
      .pulse_q    (div_pulse)
   );
endmodule

// File: rtl/fracn_fbdiv_chk.sv
module fracn_fbdiv_chk #(
   parameter int NW   = 7,
   parameter int NMIN = 4
) (
   input logic        clk,
   input logic        rst,
   input logic        ce_in,
   input logic        div_pulse,
   input logic [NW:0] cur_mod,
   input logic        carry_out,
   input logic [NW:0] cnt
);
   logic armed;
   always_ff @(posedge clk) armed <= !rst;

   // R2
   pulse_after_ce_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      div_pulse |-> $past(ce_in));
   // R2
   pulse_single_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      div_pulse |=> !div_pulse);
   // R2
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      cnt < cur_mod);
   // R8
   mod_held_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      !div_pulse |-> ($stable(cur_mod) && $stable(carry_out)));
   // R7
   mod_floor_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      cur_mod >= (NW+1)'(NMIN));
   // R4
   carry_mod_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      carry_out |-> (cur_mod > (NW+1)'(NMIN)));
endmodule

bind fracn_fbdiv fracn_fbdiv_chk #(.NW(NW), .NMIN(NMIN)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ce_in     (ce_in),
   .div_pulse (div_pulse),
   .cur_mod   (cur_mod),
   .carry_out (carry_out),
   .cnt       (cnt_q)
);

// File: tb/tb_fracn_fbdiv.sv
module tb_fracn_fbdiv;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst = 1'b1, ce_in = 1'b0, dither_en = 1'b0;
   logic [6:0]  int_n = 7'd4;
   logic [19:0] frac_num = '0, frac_mod = 20'd1;
   logic        div_pulse, carry_out;
   logic [7:0]  cur_mod;

   fracn_fbdiv dut (
      .clk(clk), .rst(rst), .ce_in(ce_in), .int_n(int_n),
      .frac_num(frac_num), .frac_mod(frac_mod), .dither_en(dither_en),
      .div_pulse(div_pulse), .cur_mod(cur_mod), .carry_out(carry_out)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int lens [4000];
   int mods [4000];
   bit cars [4000];
   int np;

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run(int n, longint f, longint m, bit d, int pat, int k,
                      int chg_at, int n2, longint f2, longint m2);
      int since, cyc, mprev, nc;
      bit pce, cprev;
      nc = (n < 4) ? 4 : n;
      int_n = 7'(n); frac_num = 20'(f); frac_mod = 20'(m); dither_en = d;
      ce_in = 1'b0; rst = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(div_pulse == 1'b0 && carry_out == 1'b0 && cur_mod == 8'(nc),
          "R1 reset state", longint'(cur_mod), nc);
      rst = 1'b0; np = 0; since = 0; cyc = 0;
      mprev = int'(cur_mod); cprev = carry_out;
      while (np < k && cyc < 60000) begin
         case (pat)
            0:       ce_in = 1'b1;
            1:       ce_in = (cyc % 3 == 0);
            default: ce_in = 1'($urandom % 2);
         endcase
         pce = ce_in;
         @(negedge clk);
         cyc++;
         since += int'(pce);
         if (chg_at >= 0 && np == chg_at && since == 1 && !div_pulse) begin
            int_n = 7'(n2); frac_num = 20'(f2); frac_mod = 20'(m2);
         end
         if (div_pulse) begin
            lens[np] = since; mods[np] = mprev; cars[np] = cprev;
            np++; since = 0;
            mprev = int'(cur_mod); cprev = carry_out;
         end
      end
      ce_in = 1'b0;
      chk(np == k, "R2 periods completed", np, k);
   endtask

   task automatic verify(int n, longint f, longint m, bit exact, string tag);
      int nc, bad2, bad4, bad3, ones, badk;
      longint expo, win;
      bit valid;
      nc = (n < 4) ? 4 : n;
      valid = (f != 0) && (f < m);
      chk(lens[0] == nc, "R1 first period", lens[0], nc);
      bad2 = 0; bad4 = 0;
      for (int k = 0; k < np; k++) begin
         if (lens[k] != mods[k]) bad2++;
         if (cars[k] != (mods[k] == nc + 1)) bad4++;
      end
      chk(bad2 == 0, "R2 length matches cur_mod", bad2, 0);
      chk(bad4 == 0, "R4 carry_out marks N+1", bad4, 0);
      if (exact) begin
         ones = 0; bad3 = 0; badk = -1; expo = 0;
         for (int k = 1; k < np; k++) begin
            if (lens[k] == nc + 1) ones++;
            else if (lens[k] != nc) bad3++;
            expo = valid ? (longint'(k) * f) / m : 0;
            if (ones != expo && badk < 0) badk = k;
         end
         chk(bad3 == 0 && badk < 0, tag, badk, -1);
         if (valid && np >= m + 1) begin
            win = 0;
            for (int k = 1; k <= m; k++) win += lens[k];
            chk(win == m * nc + f, tag, win, m * nc + f);
         end
      end
   endtask

   initial begin
      int ones, div_at;
      longint expo, diff;
      // R3 sweep over small fractions, two N values, three enable patterns
      for (int n = 4; n <= 5; n++)
         for (int m = 1; m <= 8; m++)
            for (int f = 0; f < m; f++) begin
               run(n, f, m, 0, (m + f) % 3, 2 * m + 2, -1, 0, 0, 0);
               verify(n, f, m, 1, (f == 0) ? "R5 zero fraction" : "R3 carry count");
            end
      // R3 full-width modulus and sparse carry
      run(100, 20'hFFFFE, 20'hFFFFF, 0, 0, 200, -1, 0, 0, 0);
      verify(100, 20'hFFFFE, 20'hFFFFF, 1, "R3 wide modulus");
      run(4, 1, 1000, 0, 0, 1002, -1, 0, 0, 0);
      verify(4, 1, 1000, 1, "R3 sparse window");
      // R5 zero fraction with dither on
      run(6, 0, 9, 1, 2, 40, -1, 0, 0, 0);
      verify(6, 0, 9, 1, "R5 zero fraction dithered");
      // R6 improper fraction and zero modulus with dither on
      run(5, 7, 7, 1, 2, 30, -1, 0, 0, 0);
      verify(5, 7, 7, 1, "R6 F equals M");
      run(5, 3, 0, 1, 0, 30, -1, 0, 0, 0);
      verify(5, 3, 0, 1, "R6 zero modulus");
      // R7 clamp of small N
      run(1, 1, 2, 0, 1, 20, -1, 0, 0, 0);
      verify(1, 1, 2, 1, "R7 N=1 clamped");
      run(0, 0, 1, 0, 0, 10, -1, 0, 0, 0);
      verify(0, 0, 1, 1, "R7 N=0 clamped");
      // R8 reprogram mid-period: N 5->9, F/M 0/1 -> 1/2
      run(5, 0, 1, 0, 0, 6, 1, 9, 1, 2);
      chk(lens[1] == 5, "R8 period in progress kept", lens[1], 5);
      chk(lens[2] == 9, "R8 first new period", lens[2], 9);
      chk(lens[3] == 10, "R8 second new period", lens[3], 10);
      // R9 dithered long run
      run(4, 1, 3, 1, 2, 3000, -1, 0, 0, 0);
      verify(4, 1, 3, 0, "R9");
      ones = 0; div_at = -1;
      for (int k = 1; k < np; k++) begin
         if (lens[k] == 5) ones++;
         if (div_at < 0 && longint'(ones) != (longint'(k) * 1) / 3) div_at = k;
      end
      expo = (longint'(np - 1)) / 3;
      diff = longint'(ones) - expo;
      if (diff < 0) diff = -diff;
      chk(diff <= 2, "R9 dithered mean", ones, expo);
      chk(div_at > 0, "R9 pattern departs from undithered", div_at, 1);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R2 actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule